// File: doc/BRIEF.md
# ALU with Condition-Code Evaluation

This block is the execute-stage arithmetic unit of a small 32-bit processor. Each cycle it combines two register operands under a function code and presents the result combinationally. When the set-flags enable is high at a rising clock edge, it captures three condition flags from that result: zero, sign and signed overflow.

A second function field selects one of seven conditions, which are evaluated against the stored flags. The single "condition true" output serves both conditional branches and conditional register moves. The move path writes its destination only when this output is high. The branch path uses the always-true code for an unconditional jump.

Top module: `alu_cc_unit`

## Requirements
- R1: With `alu_fn` = 0, `result` is `op_a + op_b` modulo 2^32, combinationally in the same cycle.
- R2: With `alu_fn` = 1, `result` is `op_b - op_a` modulo 2^32.
- R3: With `alu_fn` = 2, `result` is the bitwise AND of the operands. With `alu_fn` = 3, it is the bitwise XOR. Any `alu_fn` from 4 to 15 gives a result of zero.
- R4: At a rising edge with `set_cc` high, ZF takes the value (`result` == 0) and SF takes `result[31]`. The flags are visible on `cc_flags`, with bit 2 = ZF, bit 1 = SF and bit 0 = OF.
- R5: At a rising edge with `set_cc` high, OF is set on signed overflow for codes 0 and 1. Signed overflow means same-sign operands giving an opposite-sign sum for add, or operands of differing sign where the difference's sign differs from `op_b` for subtract. OF is cleared for every other code.
- R6: At a rising edge with `set_cc` low, all three flags keep their values, whatever the operands and function code are.
- R7: While `rst_n` is low, the flags are forced to ZF=1, SF=0, OF=0.
- R8: `cond_true` is computed combinationally from the stored flags and `cond_fn`. Let L = SF xor OF. The codes are: 0 always true, 1 (L or ZF), 2 L, 3 ZF, 4 not ZF, 5 not L, 6 not (L or ZF). Codes 7 to 15 are false.
- R9: `cond_true` depends only on the registered flags. Operands and function code applied in the current cycle do not change it until the flags are captured at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 32 | First operand (subtrahend for subtract) |
| op_b | input | 32 | Second operand |
| alu_fn | input | 4 | Operation select |
| set_cc | input | 1 | Capture flags at the next rising edge |
| cond_fn | input | 4 | Condition select |
| result | output | 32 | Operation result |
| cond_true | output | 1 | Selected condition holds on the stored flags |
| cc_flags | output | 3 | Stored flags {ZF, SF, OF} |

## Verification
The checker watches the flag register on every cycle. It confirms that the flags are stable whenever `set_cc` was low, and that ZF and SF follow the previous cycle's result when `set_cc` was high. It also confirms that OF is cleared after logic operations and that the always, equal and not-equal conditions track the stored flags. The exact arithmetic values need the bench's directed vectors: wraparound, overflow at both signed extremes, subtract operand order and undefined function codes. The same holds for the full table of conditions, which is swept across flag states with mixed signs.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

    localparam int unsigned FN_W = 4;

    typedef enum logic [FN_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_XOR = 4'd3
    } alu_op_e;

    typedef enum logic [FN_W-1:0] {
        CND_ALWAYS = 4'd0,
        CND_LE     = 4'd1,
        CND_LT     = 4'd2,
        CND_EQ     = 4'd3,
        CND_NE     = 4'd4,
        CND_GE     = 4'd5,
        CND_GT     = 4'd6
    } cond_sel_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } cc_flags_t;

    localparam cc_flags_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_cc_datapath.sv
module alu_cc_datapath
    import alu_cc_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [FN_W-1:0]  fn_i,
    output logic [WIDTH-1:0] res_o,
    output cc_flags_t        cc_o
);

    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] diff_w;
    logic             ovf_add_w;
    logic             ovf_sub_w;

    always_comb begin
        sum_w     = b_i + a_i;
        diff_w    = b_i - a_i;
        ovf_add_w = (a_i[MSB] == b_i[MSB]) && (sum_w[MSB] != a_i[MSB]);
        ovf_sub_w = (a_i[MSB] != b_i[MSB]) && (diff_w[MSB] != b_i[MSB]);
    end

    always_comb begin
        res_o   = '0;
        cc_o.of = 1'b0;
        case (fn_i)
            OP_ADD: begin
                res_o   = sum_w;
                cc_o.of = ovf_add_w;
            end
            OP_SUB: begin
                res_o   = diff_w;
                cc_o.of = ovf_sub_w;
            end
            OP_AND:  res_o = a_i & b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            default: res_o = '0;
        endcase
        cc_o.zf = (res_o == '0);
        cc_o.sf = res_o[MSB];
    end

endmodule

// File: rtl/alu_cc_cond.sv
module alu_cc_cond
    import alu_cc_pkg::*;
(
    input  cc_flags_t       cc_i,
    input  logic [FN_W-1:0] sel_i,
    output logic            hit_o
);

    logic lt_w;
    logic le_w;

    always_comb begin
        lt_w = cc_i.sf ^ cc_i.of;
        le_w = lt_w | cc_i.zf;
        case (sel_i)
            CND_ALWAYS: hit_o = 1'b1;
            CND_LE:     hit_o = le_w;
            CND_LT:     hit_o = lt_w;
            CND_EQ:     hit_o = cc_i.zf;
            CND_NE:     hit_o = ~cc_i.zf;
            CND_GE:     hit_o = ~lt_w;
            CND_GT:     hit_o = ~le_w;
            default:    hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
    import alu_cc_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       alu_fn,
    input  logic             set_cc,
    input  logic [3:0]       cond_fn,
    output logic [WIDTH-1:0] result,
    output logic             cond_true,
    output logic [2:0]       cc_flags
);

    typedef struct packed {
        cc_flags_t cc;
    } state_t;

    state_t    st_d;
    state_t    st_q;
    cc_flags_t cc_new_w;

    alu_cc_datapath #(.WIDTH(WIDTH)) u_dp (
        .a_i   (op_a),
        .b_i   (op_b),
        .fn_i  (alu_fn),
        .res_o (result),
        .cc_o  (cc_new_w)
    );

    alu_cc_cond u_cond (
        .cc_i  (st_q.cc),
        .sel_i (cond_fn),
        .hit_o (cond_true)
    );

    always_comb begin
        st_d = st_q;
        if (set_cc) begin
            st_d.cc = cc_new_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cc <= CC_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cc_flags = st_q.cc;

endmodule

// File: rtl/alu_cc_chk.sv
module alu_cc_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] result,
    input logic [3:0]       alu_fn,
    input logic             set_cc,
    input logic [3:0]       cond_fn,
    input logic             cond_true,
    input logic [2:0]       cc_flags
);

    // R6: flags held when capture was not requested
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !set_cc |=> $stable(cc_flags));

    // R4: zero flag follows the result seen at the capturing edge
    p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_cc |=> (cc_flags[2] == ($past(result) == '0)));

    // R4: sign flag follows the result's top bit
    p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_cc |=> (cc_flags[1] == $past(result[WIDTH-1])));

    // R5: logic and undefined codes clear the overflow flag
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cc && (alu_fn > 4'd1)) |=> !cc_flags[0]);

    // R8: always-true code
    p_always_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_fn == 4'd0) |-> cond_true);

    // R8: equal and not-equal track the stored zero flag
    p_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_fn == 4'd3) |-> (cond_true == cc_flags[2]));

    p_nequal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_fn == 4'd4) |-> (cond_true != cc_flags[2]));

    // R8: out-of-range codes never hold
    p_unused_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_fn > 4'd6) |-> !cond_true);

endmodule

bind alu_cc_unit alu_cc_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .result    (result),
    .alu_fn    (alu_fn),
    .set_cc    (set_cc),
    .cond_fn   (cond_fn),
    .cond_true (cond_true),
    .cc_flags  (cc_flags)
);

// File: tb/alu_cc_unit_tb_top.sv
`timescale 1ns/1ps
module alu_cc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  alu_fn = '0;
    logic        set_cc = 1'b0;
    logic [3:0]  cond_fn = '0;
    logic [31:0] result;
    logic        cond_true;
    logic [2:0]  cc_flags;

    always #4 clk = ~clk;

    alu_cc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .alu_fn(alu_fn),
        .set_cc(set_cc), .cond_fn(cond_fn), .result(result),
        .cond_true(cond_true), .cc_flags(cc_flags)
    );

    typedef struct {
        logic [31:0] res;
        logic        cnd;
        logic [2:0]  flg;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 0;
    logic [2:0]  mdl_flg = 3'b100;

    function automatic logic mdl_cond(input logic [2:0] f, input logic [3:0] c);
        logic lt, le;
        lt = f[1] ^ f[0];
        le = lt | f[2];
        case (c)
            4'd0: return 1'b1;
            4'd1: return le;
            4'd2: return lt;
            4'd3: return f[2];
            4'd4: return !f[2];
            4'd5: return !lt;
            4'd6: return !le;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [3:0] fn, input logic [31:0] a,
                         input logic [31:0] b, input logic sc, input logic [3:0] cf);
        item_t it;
        logic [31:0] r;
        logic ov;
        @(negedge clk);
        op_a = a; op_b = b; alu_fn = fn; set_cc = sc; cond_fn = cf;
        ov = 1'b0;
        case (fn)
            4'd0: begin r = a + b; ov = (a[31] == b[31]) && (r[31] != a[31]); end
            4'd1: begin r = b - a; ov = (a[31] != b[31]) && (r[31] != b[31]); end
            4'd2: r = a & b;
            4'd3: r = a ^ b;
            default: r = '0;
        endcase
        it.res = r;
        it.cnd = mdl_cond(mdl_flg, cf);
        if (sc) mdl_flg = {(r == 32'd0), r[31], ov};
        it.flg = mdl_flg;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check({it.tag, " result"}, result, it.res);
                check({it.tag, " cond R8 R9"}, {31'd0, cond_true}, {31'd0, it.cnd});
                @(posedge clk);
                #1;
                check({it.tag, " flags"}, {29'd0, cc_flags}, {29'd0, it.flg});
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        // R7: reset values
        check("R7 reset flags", {29'd0, cc_flags}, 32'd4);
        rst_n = 1'b1;
        cond_fn = 4'd3;
        #1;
        check("R7 eq after reset", {31'd0, cond_true}, 32'd1);

        drive("R1 add", 4'd0, 32'd5, 32'd7, 1'b1, 4'd3);
        drive("R1 R4 add wrap", 4'd0, 32'hFFFF_FFFF, 32'd1, 1'b1, 4'd4);
        drive("R5 add ovf", 4'd0, 32'h7FFF_FFFF, 32'd1, 1'b1, 4'd3);
        drive("R5 add neg ovf", 4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 4'd2);
        drive("R2 sub", 4'd1, 32'd3, 32'd10, 1'b1, 4'd2);
        drive("R2 R5 sub ovf", 4'd1, 32'd1, 32'h8000_0000, 1'b1, 4'd0);
        drive("R2 R4 sub neg", 4'd1, 32'd10, 32'd3, 1'b1, 4'd5);
        drive("R3 and", 4'd2, 32'hF0F0_1234, 32'hFF00_FFFF, 1'b1, 4'd1);
        drive("R3 xor", 4'd3, 32'hA5A5_A5A5, 32'h0F0F_0F0F, 1'b1, 4'd6);
        drive("R3 xor eq", 4'd3, 32'h1234_5678, 32'h1234_5678, 1'b1, 4'd3);
        drive("R3 R5 undef", 4'd9, 32'h7FFF_FFFF, 32'd1, 1'b1, 4'd4);
        drive("R5 pre", 4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 4'd1);
        drive("R5 and clears", 4'd2, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 4'd2);
        // R6: hold with busy inputs; R9 current op does not sway cond
        drive("R6 hold add", 4'd0, 32'd0, 32'd0, 1'b0, 4'd3);
        drive("R6 R9 hold sub", 4'd1, 32'd1, 32'h8000_0000, 1'b0, 4'd2);
        // R8: sweep all codes over several flag states
        for (int s = 0; s < 4; s++) begin
            case (s)
                0: drive("R8 set pos", 4'd1, 32'd2, 32'd9, 1'b1, 4'd0);
                1: drive("R8 set zero", 4'd1, 32'd9, 32'd9, 1'b1, 4'd0);
                2: drive("R8 set neg", 4'd1, 32'd9, 32'd2, 1'b1, 4'd0);
                default: drive("R8 set ovf", 4'd1, 32'd1, 32'h8000_0000, 1'b1, 4'd0);
            endcase
            for (int c = 0; c < 16; c++) begin
                drive("R8 R6 sweep", 4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, c[3:0]);
            end
        end
        // R7: reset mid-run
        @(negedge clk);
        set_cc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R7 async reset", {29'd0, cc_flags}, 32'd4);
        @(negedge clk);
        rst_n = 1'b1;
        mdl_flg = 3'b100;
        drive("R7 R8 after reset", 4'd0, 32'd1, 32'd1, 1'b0, 4'd1);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule